// File: doc/BRIEF.md
# Full-Frame CCD Clock Sequencer

This block produces the digital phase sequence that moves charge through a full-frame CCD built from four vertical zones and two horizontal readout registers. One start pulse runs a whole frame. First comes a cleaning pass that flushes every line with the output reset held on. Next comes an integration wait of programmable length. Last comes readout: each line is moved into the readout registers and then shifted out pixel by pixel.

The readout mode sets three things: the number of line transfers, the number of pixel periods per line, and which horizontal register or registers are driven. The system clock sets the time base. A line transfer is measured in base periods of `t0_div_i` system clocks. A pixel period lasts `pix_div_i` system clocks. Integration is counted in base periods. All three values, and the mode, are captured at start and then held fixed for the whole frame. During every pixel period a class tag tells downstream logic whether the sample is prescan, dark reference, isolation or image data.

Top module: `ccd_frame_seq`

## Requirements
- R1: A high `start_i` sampled while idle starts a frame, and `busy_o` is high from the next cycle until the last pixel period of the last line ends. `start_i`, `mode_i`, `t0_div_i`, `pix_div_i` and `int_len_i` have no effect while busy.
- R2: Mode decode. Mode 0: NBV_FULL lines, NBH_ONE pixels, bottom register only (enable bit 1). Mode 1: NBV_FULL lines, NBH_ONE pixels, top register only (enable bit 0). Mode 2: NBV_THREE lines, NBH_ONE pixels, both registers. Mode 3: NBV_QUAD lines, NBH_TWO pixels, both registers. The defaults are 3508, 2631, 1754, 2336 and 1186.
- R3: A line transfer lasts 11 slots of `t0_div_i` cycles each. The phases on `vphase_o` are bit 0=A, 1=B, 2=C, 3=D. A is low in slots 2-4, B is low in slots 4-6, C is high in slots 1-5 and D is high in slots 3-7. Outside a line transfer the value is 4'b0011.
- R4: Cleaning runs the line count of the mode as back-to-back line transfers. During cleaning `reset_o` stays high, `tag_o` is 0 and the enabled horizontal clocks stay low.
- R5: Integration follows cleaning directly. It lasts `int_len_i`×`t0_div_i` cycles, with the vertical phases idle and `reset_o` low. A length of 0 skips integration.
- R6: Readout runs, for each line, a line transfer followed at once by the mode's pixel periods, with no idle cycles anywhere in the frame.
- R7: In pixel cycle c of a period of P=`pix_div_i` (at least 4) cycles, `reset_o` is high for c=0, L1 is high for 1≤c<P/2 and L2 is high for c≥P/2. L1 and L2 of an enabled register are never both high.
- R8: `tag_o` is 0 outside pixel periods. Within a line, the first 12 periods carry 1 (prescan), the next 16 carry 2 (dark), the next 8 carry 3 (isolation) and the rest carry 4 (image).
- R9: `tgate_o[r]` follows phase A during line transfers when register r is enabled, and is low otherwise.
- R10: The L1 and L2 outputs of a register that is not enabled are both held high. After reset neither register is enabled.
- R11: After reset `busy_o`, `reset_o`, `tgate_o` and `tag_o` are 0 and `vphase_o` is 4'b0011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start request |
| mode_i | input | 2 | Readout mode (0..3) |
| t0_div_i | input | T0W | Base period in clocks (at least 1) |
| pix_div_i | input | PXW | Pixel period in clocks (at least 4) |
| int_len_i | input | INTW | Integration length in base periods |
| busy_o | output | 1 | Frame in progress |
| vphase_o | output | 4 | Vertical phases A..D |
| tgate_o | output | 2 | Transfer gates, bit 0 top, bit 1 bottom |
| hreg_l1_o | output | 2 | L1 clock per register |
| hreg_l2_o | output | 2 | L2 clock per register |
| reset_o | output | 1 | Output node reset |
| tag_o | output | 3 | Pixel class tag |

## Verification
The assertions assume that `t0_div_i` is at least 1, that `pix_div_i` is at least 4, and that the configuration inputs only need to be valid in the cycle where a start is accepted. If these assumptions are broken, the pixel period has no L1 window and the counters wrap. The stimulus only ever supplies base periods of 1 to 3 and pixel periods of 4 to 6, and it changes the mode and the base period in the middle of a frame to show those changes are ignored. A behavioural model, built from the requirement text, produces the expected value of every output for every cycle of each frame. The frames cover all four modes, integration lengths including zero, and odd pixel periods.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  typedef enum logic [2:0] {
    TAG_NONE    = 3'd0,
    TAG_PRESCAN = 3'd1,
    TAG_DARK    = 3'd2,
    TAG_ISOL    = 3'd3,
    TAG_IMAGE   = 3'd4
  } pix_tag_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CLEAN, ST_INTEG, ST_READ_V, ST_READ_H
  } seq_state_e;

  localparam int          VSLOTS     = 11;
  localparam logic [3:0]  VPH_IDLE   = 4'b0011;

  // {D,C,B,A} per slot of a line transfer
  function automatic logic [3:0] vphase_at(input logic [3:0] slot);
    case (slot)
      4'd1:    return 4'b0111;
      4'd2:    return 4'b0110;
      4'd3:    return 4'b1110;
      4'd4:    return 4'b1100;
      4'd5:    return 4'b1101;
      4'd6:    return 4'b1001;
      4'd7:    return 4'b1011;
      default: return VPH_IDLE;
    endcase
  endfunction

  function automatic logic [1:0] mode_reg_en(input logic [1:0] mode);
    case (mode)
      2'd0:    return 2'b10;
      2'd1:    return 2'b01;
      default: return 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/ccd_vert_gen.sv
module ccd_vert_gen import ccd_seq_pkg::*; #(
  parameter int T0W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           go_i,
  input  logic [T0W-1:0] t0_div_i,
  output logic           active_o,
  output logic           done_o,
  output logic [3:0]     phase_o
);
  logic [T0W-1:0] tick_q;
  logic [3:0]     slot_q;
  logic           last_tick;

  assign last_tick = (tick_q == t0_div_i - T0W'(1));
  assign done_o    = active_o && last_tick && (slot_q == 4'(VSLOTS - 1));
  assign phase_o   = active_o ? vphase_at(slot_q) : VPH_IDLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      tick_q   <= '0;
      slot_q   <= '0;
    end else if (go_i) begin
      active_o <= 1'b1;
      tick_q   <= '0;
      slot_q   <= '0;
    end else if (active_o) begin
      if (last_tick) begin
        tick_q <= '0;
        slot_q <= slot_q + 4'd1;
        if (done_o) active_o <= 1'b0;
      end else begin
        tick_q <= tick_q + T0W'(1);
      end
    end
  end
endmodule

// File: rtl/ccd_horiz_gen.sv
module ccd_horiz_gen import ccd_seq_pkg::*; #(
  parameter int PXW    = 8,
  parameter int CW     = 12,
  parameter int PRE_N  = 12,
  parameter int DARK_N = 16,
  parameter int ISO_N  = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           go_i,
  input  logic [PXW-1:0] pix_div_i,
  input  logic [CW-1:0]  nbh_i,
  output logic           done_o,
  output logic           l1_o,
  output logic           l2_o,
  output logic           rst_o,
  output pix_tag_e       tag_o
);
  localparam int DARK_END = PRE_N + DARK_N;
  localparam int ISO_END  = DARK_END + ISO_N;

  logic           active_q;
  logic [PXW-1:0] ph_q, half;
  logic [CW-1:0]  pix_q;
  logic           last_ph;

  assign half    = pix_div_i >> 1;
  assign last_ph = (ph_q == pix_div_i - PXW'(1));
  assign done_o  = active_q && last_ph && (pix_q == nbh_i - CW'(1));
  assign rst_o   = active_q && (ph_q == '0);
  assign l1_o    = active_q && (ph_q != '0) && (ph_q < half);
  assign l2_o    = active_q && (ph_q >= half);

  always_comb begin
    if (!active_q)                  tag_o = TAG_NONE;
    else if (pix_q < CW'(PRE_N))    tag_o = TAG_PRESCAN;
    else if (pix_q < CW'(DARK_END)) tag_o = TAG_DARK;
    else if (pix_q < CW'(ISO_END))  tag_o = TAG_ISOL;
    else                            tag_o = TAG_IMAGE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ph_q     <= '0;
      pix_q    <= '0;
    end else if (go_i) begin
      active_q <= 1'b1;
      ph_q     <= '0;
      pix_q    <= '0;
    end else if (active_q) begin
      if (last_ph) begin
        ph_q  <= '0;
        pix_q <= pix_q + CW'(1);
        if (done_o) active_q <= 1'b0;
      end else begin
        ph_q <= ph_q + PXW'(1);
      end
    end
  end
endmodule

// File: rtl/ccd_frame_seq.sv
module ccd_frame_seq import ccd_seq_pkg::*; #(
  parameter int T0W       = 8,
  parameter int PXW       = 8,
  parameter int INTW      = 16,
  parameter int NBV_FULL  = 3508,
  parameter int NBV_THREE = 2631,
  parameter int NBV_QUAD  = 1754,
  parameter int NBH_ONE   = 2336,
  parameter int NBH_TWO   = 1186,
  parameter int PRE_N     = 12,
  parameter int DARK_N    = 16,
  parameter int ISO_N     = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [1:0]      mode_i,
  input  logic [T0W-1:0]  t0_div_i,
  input  logic [PXW-1:0]  pix_div_i,
  input  logic [INTW-1:0] int_len_i,
  output logic            busy_o,
  output logic [3:0]      vphase_o,
  output logic [1:0]      tgate_o,
  output logic [1:0]      hreg_l1_o,
  output logic [1:0]      hreg_l2_o,
  output logic            reset_o,
  output logic [2:0]      tag_o
);
  localparam int MAXC = (NBV_FULL > NBH_ONE) ? NBV_FULL : NBH_ONE;
  localparam int CW   = $clog2(MAXC + 1);

  seq_state_e      st_q;
  logic [1:0]      mode_q, en_q;
  logic [T0W-1:0]  t0_q, itick_q;
  logic [PXW-1:0]  pix_q;
  logic [INTW-1:0] int_q, iunit_q;
  logic [CW-1:0]   line_q, nbv, nbh;
  logic            last_line, int_done, v_go, h_go;
  logic            v_active, v_done, h_done, h_l1, h_l2, h_rst;
  pix_tag_e        h_tag;

  always_comb begin
    case (mode_q)
      2'd0, 2'd1: begin nbv = CW'(NBV_FULL);  nbh = CW'(NBH_ONE); end
      2'd2:       begin nbv = CW'(NBV_THREE); nbh = CW'(NBH_ONE); end
      default:    begin nbv = CW'(NBV_QUAD);  nbh = CW'(NBH_TWO); end
    endcase
  end

  assign last_line = (line_q == nbv - CW'(1));
  assign int_done  = (st_q == ST_INTEG) && (itick_q == t0_q - T0W'(1)) &&
                     (iunit_q == int_q - INTW'(1));
  assign v_go = ((st_q == ST_IDLE)   && start_i) ||
                ((st_q == ST_CLEAN)  && v_done && (!last_line || int_q == '0)) ||
                int_done ||
                ((st_q == ST_READ_H) && h_done && !last_line);
  assign h_go = (st_q == ST_READ_V) && v_done;

  ccd_vert_gen #(.T0W(T0W)) u_vert (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (v_go),
    .t0_div_i (t0_q),
    .active_o (v_active),
    .done_o   (v_done),
    .phase_o  (vphase_o)
  );

  ccd_horiz_gen #(
    .PXW(PXW), .CW(CW), .PRE_N(PRE_N), .DARK_N(DARK_N), .ISO_N(ISO_N)
  ) u_horiz (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (h_go),
    .pix_div_i (pix_q),
    .nbh_i     (nbh),
    .done_o    (h_done),
    .l1_o      (h_l1),
    .l2_o      (h_l2),
    .rst_o     (h_rst),
    .tag_o     (h_tag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      mode_q  <= '0;
      en_q    <= '0;
      t0_q    <= T0W'(1);
      pix_q   <= PXW'(4);
      int_q   <= '0;
      line_q  <= '0;
      itick_q <= '0;
      iunit_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          mode_q <= mode_i;
          en_q   <= mode_reg_en(mode_i);
          t0_q   <= t0_div_i;
          pix_q  <= pix_div_i;
          int_q  <= int_len_i;
          line_q <= '0;
          st_q   <= ST_CLEAN;
        end
        ST_CLEAN: if (v_done) begin
          if (last_line) begin
            line_q  <= '0;
            itick_q <= '0;
            iunit_q <= '0;
            st_q    <= (int_q == '0) ? ST_READ_V : ST_INTEG;
          end else begin
            line_q <= line_q + CW'(1);
          end
        end
        ST_INTEG: begin
          if (itick_q == t0_q - T0W'(1)) begin
            itick_q <= '0;
            iunit_q <= iunit_q + INTW'(1);
          end else begin
            itick_q <= itick_q + T0W'(1);
          end
          if (int_done) st_q <= ST_READ_V;
        end
        ST_READ_V: if (v_done) st_q <= ST_READ_H;
        ST_READ_H: if (h_done) begin
          if (last_line) begin
            st_q <= ST_IDLE;
          end else begin
            line_q <= line_q + CW'(1);
            st_q   <= ST_READ_V;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign reset_o   = (st_q == ST_CLEAN) || h_rst;
  assign tag_o     = h_tag;
  assign tgate_o   = en_q & {2{v_active & vphase_o[0]}};
  assign hreg_l1_o = (en_q & {2{h_l1}}) | ~en_q;
  assign hreg_l2_o = (en_q & {2{h_l2}}) | ~en_q;
endmodule

// File: rtl/ccd_frame_seq_chk.sv
module ccd_frame_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic [3:0] vphase_o,
  input logic [1:0] tgate_o,
  input logic [1:0] hreg_l1_o,
  input logic [1:0] hreg_l2_o,
  input logic       reset_o,
  input logic [2:0] tag_o,
  input logic [1:0] reg_en_i
);
  // R1
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && tag_o == 3'd0 && !reset_o |=> busy_o);

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!reset_o && tag_o == 3'd0));

  // R6
  vert_idle_in_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_o != 3'd0 |-> vphase_o == 4'b0011);

  // R9
  gate_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgate_o != 2'b00 |-> busy_o && vphase_o[0]);

  // R8
  tag_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_o <= 3'd4);

  for (genvar r = 0; r < 2; r++) begin : g_reg
    // R7
    no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reg_en_i[r] |-> !(hreg_l1_o[r] && hreg_l2_o[r]));

    // R7
    reset_before_l1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && reg_en_i[r] && $rose(hreg_l1_o[r]) |-> $past(reset_o));

    // R10
    unused_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !reg_en_i[r] |-> (hreg_l1_o[r] && hreg_l2_o[r]));
  end
endmodule

bind ccd_frame_seq ccd_frame_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .vphase_o  (vphase_o),
  .tgate_o   (tgate_o),
  .hreg_l1_o (hreg_l1_o),
  .hreg_l2_o (hreg_l2_o),
  .reset_o   (reset_o),
  .tag_o     (tag_o),
  .reg_en_i  (en_q)
);

// File: tb/ccd_frame_seq_test.sv
module ccd_frame_seq_test;
  localparam int NV_FULL = 3, NV_THREE = 2, NV_QUAD = 4;
  localparam int NH_ONE = 44, NH_TWO = 40;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [7:0]  t0_div_i = 8'd1, pix_div_i = 8'd4;
  logic [15:0] int_len_i = '0;
  logic        busy_o, reset_o;
  logic [3:0]  vphase_o;
  logic [1:0]  tgate_o, hreg_l1_o, hreg_l2_o;
  logic [2:0]  tag_o;

  int checks = 0, errors = 0;
  int busy_cnt = 0, image_cnt = 0;
  logic        cmp_on = 1'b0;
  logic [14:0] exp_q[$];
  logic [14:0] idle_v;

  always #5 clk_i = ~clk_i;

  ccd_frame_seq #(
    .NBV_FULL(NV_FULL), .NBV_THREE(NV_THREE), .NBV_QUAD(NV_QUAD),
    .NBH_ONE(NH_ONE), .NBH_TWO(NH_TWO)
  ) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .t0_div_i(t0_div_i), .pix_div_i(pix_div_i), .int_len_i(int_len_i),
    .busy_o(busy_o), .vphase_o(vphase_o), .tgate_o(tgate_o),
    .hreg_l1_o(hreg_l1_o), .hreg_l2_o(hreg_l2_o), .reset_o(reset_o), .tag_o(tag_o)
  );

  // {busy, vph[3:0], tg[1:0], l1[1:0], l2[1:0], rst, tag[2:0]}
  function automatic logic [14:0] vec(logic b, logic [3:0] v, logic [1:0] g,
                                      logic [1:0] a, logic [1:0] c, logic r, logic [2:0] t);
    return {b, v, g, a, c, r, t};
  endfunction

  function automatic logic [3:0] slot_phase(int s);
    logic pa, pb, pc, pd;
    pa = !(s >= 2 && s <= 4);
    pb = !(s >= 4 && s <= 6);
    pc = (s >= 1 && s <= 5);
    pd = (s >= 3 && s <= 7);
    return {pd, pc, pb, pa};
  endfunction

  task automatic check(string req, int act, int exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp_v, $time);
    end
  endtask

  always @(negedge clk_i) if (cmp_on) begin
    logic [14:0] e;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : idle_v;
    if (busy_o) busy_cnt++;
    if (tag_o == 3'd4) image_cnt++;
    check("R1 busy", busy_o, e[14]);
    check("R3 vphase", vphase_o, e[13:10]);
    check("R9 tgate", tgate_o, e[9:8]);
    check("R7 R10 hreg_l1", hreg_l1_o, e[7:6]);
    check("R7 R10 hreg_l2", hreg_l2_o, e[5:4]);
    check("R4 R7 reset", reset_o, e[3]);
    check("R8 tag", tag_o, e[2:0]);
  end

  task automatic line_xfer(int t0, logic [1:0] en, logic r);
    for (int s = 0; s < 11; s++)
      for (int k = 0; k < t0; k++) begin
        logic [3:0] v;
        v = slot_phase(s);
        exp_q.push_back(vec(1'b1, v, en & {2{v[0]}}, ~en, ~en, r, 3'd0));
      end
  endtask

  task automatic run_frame(int mode, int t0, int pd, int il, bit disturb);
    logic [1:0] en;
    int nbv, nbh, exp_len, exp_img;
    en  = (mode == 0) ? 2'b10 : (mode == 1) ? 2'b01 : 2'b11;
    nbv = (mode <= 1) ? NV_FULL : (mode == 2) ? NV_THREE : NV_QUAD;
    nbh = (mode == 3) ? NH_TWO : NH_ONE;
    @(posedge clk_i); #1;
    mode_i = 2'(mode); t0_div_i = 8'(t0); pix_div_i = 8'(pd); int_len_i = 16'(il);
    start_i = 1'b1;
    busy_cnt = 0; image_cnt = 0;
    exp_q.push_back(idle_v);
    for (int l = 0; l < nbv; l++) line_xfer(t0, en, 1'b1);
    for (int k = 0; k < il * t0; k++)
      exp_q.push_back(vec(1'b1, 4'b0011, 2'b00, ~en, ~en, 1'b0, 3'd0));
    for (int l = 0; l < nbv; l++) begin
      line_xfer(t0, en, 1'b0);
      for (int p = 0; p < nbh; p++) begin
        logic [2:0] tg;
        tg = (p < 12) ? 3'd1 : (p < 28) ? 3'd2 : (p < 36) ? 3'd3 : 3'd4;
        for (int c = 0; c < pd; c++) begin
          logic h1, h2;
          h1 = (c != 0) && (c < pd / 2);
          h2 = (c >= pd / 2);
          exp_q.push_back(vec(1'b1, 4'b0011, 2'b00, (en & {2{h1}}) | ~en,
                              (en & {2{h2}}) | ~en, c == 0, tg));
        end
      end
    end
    idle_v = vec(1'b0, 4'b0011, 2'b00, ~en, ~en, 1'b0, 3'd0);
    @(posedge clk_i); #1;
    start_i = 1'b0;
    if (disturb) begin
      repeat (30) @(posedge clk_i);
      #1; start_i = 1'b1; mode_i = 2'd0; t0_div_i = 8'd7; int_len_i = 16'd9; pix_div_i = 8'd9;
      @(posedge clk_i); #1; start_i = 1'b0;
    end
    while (exp_q.size() > 0) @(negedge clk_i);
    @(negedge clk_i);
    exp_len = nbv * 11 * t0 + il * t0 + nbv * (11 * t0 + nbh * pd);
    exp_img = nbv * (nbh - 36) * pd;
    check("R5 R6 frame length", busy_cnt, exp_len);
    check("R2 image periods", image_cnt, exp_img);
  endtask

  initial begin
    idle_v = vec(1'b0, 4'b0011, 2'b00, 2'b11, 2'b11, 1'b0, 3'd0);
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    check("R11 reset busy", busy_o, 0);
    check("R11 reset vphase", vphase_o, 4'b0011);
    check("R11 reset tag/gate/reset", {tag_o, tgate_o, reset_o}, 0);
    check("R10 reset hreg", {hreg_l1_o, hreg_l2_o}, 4'hF);
    cmp_on = 1'b1;
    run_frame(0, 1, 4, 3, 1'b0);
    run_frame(1, 2, 5, 0, 1'b0);
    run_frame(2, 3, 6, 2, 1'b1);
    run_frame(3, 1, 4, 1, 1'b0);
    run_frame(0, 2, 5, 0, 1'b1);
    repeat (5) @(posedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected frame end");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule